// File: doc/BRIEF.md
# Countdown Timers and Key-Wait Unit

This unit supplies the timing and input resources of a small virtual CPU. It holds two 8-bit down-counters, one for delays and one for sound, and a divider that turns the system clock into a 60 Hz pulse. Each pulse lowers every timer that is above zero. A timer that reaches zero stays there. The sound timer also drives a tone-enable output, which is high for as long as that timer holds a value other than zero.

The unit also carries out the wait-for-key instruction for the execute stage. Execute raises `wait_req` and holds it. The unit asserts `stall`, which freezes the program counter, until a key goes from released to pressed while the wait is active. In that cycle it raises `key_found` and puts the key's number on `key_idx`. The keypad arrives as a 16-bit level vector, one bit per hexadecimal key; bit k set means key k is down. Debouncing is done before this unit.

Top module: `countdown_keywait`

## Requirements
- R1: While reset is active, and in the first cycle after it, both timer values are 0, `sound_on`, `tick`, `stall` and `key_found` are low (with `wait_req` low). A key that is already down when reset releases does not count as a new press.
- R2: `tick` is a one-cycle pulse. It is high in the cycle after clock edge number DIV·k (k ≥ 1) counted from reset release, where DIV = CLK_HZ / TICK_HZ. It is low in every other cycle.
- R3: A timer write (`dly_wr` or `snd_wr`) loads its data byte. The read port shows that byte in the next cycle.
- R4: On an edge where `tick` is high and no write occurs, a timer above zero drops by exactly one. With neither tick nor write, the timer holds its value.
- R5: A timer at zero stays at zero on a tick. It never wraps to 255.
- R6: A write on the same edge as a tick loads the written value. No decrement is applied.
- R7: `sound_on` is high exactly when the sound timer value is nonzero.
- R8: While `wait_req` is high and no key has a new press, `stall` is high and `key_found` is low.
- R9: A new press is a key bit that is 1 now and was 0 in the previous cycle. With `wait_req` high, a new press drives `key_found` high, drives `stall` low and places the key's number on `key_idx`, all in the same cycle. A key held down from before the wait does not end it.
- R10: When several keys show a new press in the same cycle, `key_idx` gives the lowest key number.
- R11: With `wait_req` low, key activity has no effect: `stall` and `key_found` stay low.
- R12: The two timers are independent. Writing one leaves the other's value and countdown unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dly_wr | input | 1 | Load strobe for the delay timer |
| dly_wdata | input | 8 | Value for the delay timer |
| snd_wr | input | 1 | Load strobe for the sound timer |
| snd_wdata | input | 8 | Value for the sound timer |
| keys | input | 16 | Keypad levels; bit k high means key k is down |
| wait_req | input | 1 | Wait-for-key request from execute, held until served |
| dly_value | output | 8 | Current delay timer value |
| snd_value | output | 8 | Current sound timer value |
| sound_on | output | 1 | Tone enable, high while the sound timer is nonzero |
| tick | output | 1 | 60 Hz pulse, one cycle wide |
| stall | output | 1 | Hold the program counter; a key wait is pending |
| key_found | output | 1 | The key wait is satisfied in this cycle |
| key_idx | output | 4 | Number of the key that satisfied the wait |

## Verification
The assertions assume that `wait_req` and `keys` change only between clock edges and are stable at each edge. They also assume that reset is applied from time zero, so the key history has a defined start. The bench drives every input at the falling edge and keeps `keys` all zero for a full cycle before each wait. Because of this, each new press seen by the checker comes from a release that the stimulus chose on purpose. Timer loads land both off and exactly on tick cycles, which covers the write-versus-tick race.

// File: rtl/cdk_pkg.sv
package cdk_pkg;
    localparam int unsigned TIMER_COUNT = 2;
    localparam int unsigned SEL_DELAY   = 0;
    localparam int unsigned SEL_SOUND   = 1;

    function automatic int unsigned tick_ratio(input int unsigned clk_hz, input int unsigned tick_hz);
        return clk_hz / tick_hz;
    endfunction
endpackage

// File: rtl/cdk_tick_div.sv
module cdk_tick_div #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned TICK_HZ = 60
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DIV = cdk_pkg::tick_ratio(CLK_HZ, TICK_HZ);
    localparam int unsigned CW  = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.tick = 1'b0;
        if (st_q.cnt == CW'(DIV - 1)) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/cdk_countdown.sv
module cdk_countdown #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic [W-1:0] val;
    } cd_st_t;

    cd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.val = wdata;
        end else if (tick && (st_q.val != '0)) begin
            st_d.val = st_q.val - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.val;
endmodule

// File: rtl/cdk_key_wait.sv
module cdk_key_wait #(
    parameter int unsigned N  = 16,
    parameter int unsigned IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  keys,
    input  logic          wait_req,
    output logic          stall,
    output logic          found,
    output logic [IW-1:0] idx
);
    typedef struct packed {
        logic [N-1:0] prev;
    } kw_st_t;

    kw_st_t       st_d, st_q;
    logic [N-1:0] fresh;
    logic         any_fresh;

    always_comb begin
        st_d      = st_q;
        st_d.prev = keys;
        fresh     = keys & ~st_q.prev;
        any_fresh = |fresh;
        idx       = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (fresh[i]) idx = IW'(i);
        end
        found = wait_req && any_fresh;
        stall = wait_req && !any_fresh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/countdown_keywait.sv
module countdown_keywait #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned TICK_HZ = 60,
    parameter int unsigned TW      = 8,
    parameter int unsigned NKEYS   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dly_wr,
    input  logic [TW-1:0]            dly_wdata,
    input  logic                     snd_wr,
    input  logic [TW-1:0]            snd_wdata,
    input  logic [NKEYS-1:0]         keys,
    input  logic                     wait_req,
    output logic [TW-1:0]            dly_value,
    output logic [TW-1:0]            snd_value,
    output logic                     sound_on,
    output logic                     tick,
    output logic                     stall,
    output logic                     key_found,
    output logic [$clog2(NKEYS)-1:0] key_idx
);
    import cdk_pkg::*;

    localparam int unsigned IW = $clog2(NKEYS);

    logic [TIMER_COUNT-1:0]         t_wr;
    logic [TIMER_COUNT-1:0][TW-1:0] t_wdata;
    logic [TIMER_COUNT-1:0][TW-1:0] t_val;

    cdk_tick_div #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    always_comb begin
        t_wr               = '0;
        t_wdata            = '0;
        t_wr[SEL_DELAY]    = dly_wr;
        t_wdata[SEL_DELAY] = dly_wdata;
        t_wr[SEL_SOUND]    = snd_wr;
        t_wdata[SEL_SOUND] = snd_wdata;
    end

    for (genvar t = 0; t < TIMER_COUNT; t++) begin : g_timer
        cdk_countdown #(.W(TW)) u_cd (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (tick),
            .wr   (t_wr[t]),
            .wdata(t_wdata[t]),
            .value(t_val[t])
        );
    end

    assign dly_value = t_val[SEL_DELAY];
    assign snd_value = t_val[SEL_SOUND];
    assign sound_on  = (t_val[SEL_SOUND] != '0);

    cdk_key_wait #(.N(NKEYS), .IW(IW)) u_kw (
        .clk     (clk),
        .rst_n   (rst_n),
        .keys    (keys),
        .wait_req(wait_req),
        .stall   (stall),
        .found   (key_found),
        .idx     (key_idx)
    );
endmodule

// File: rtl/cdk_checker.sv
module cdk_checker #(
    parameter int unsigned CLK_HZ  = 100_000_000,
    parameter int unsigned TICK_HZ = 60,
    parameter int unsigned TW      = 8,
    parameter int unsigned NKEYS   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     dly_wr,
    input logic [TW-1:0]            dly_wdata,
    input logic                     snd_wr,
    input logic [TW-1:0]            snd_wdata,
    input logic [NKEYS-1:0]         keys,
    input logic                     wait_req,
    input logic [TW-1:0]            dly_value,
    input logic [TW-1:0]            snd_value,
    input logic                     sound_on,
    input logic                     tick,
    input logic                     stall,
    input logic                     key_found,
    input logic [$clog2(NKEYS)-1:0] key_idx
);
    localparam int unsigned DIV = CLK_HZ / TICK_HZ;

    int unsigned      since_q;
    logic [NKEYS-1:0] seen_q;
    logic [NKEYS-1:0] fresh_c;
    logic [NKEYS-1:0] below_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= 0;
            seen_q  <= '1;
        end else begin
            since_q <= tick ? 1 : since_q + 1;
            seen_q  <= keys;
        end
    end

    assign fresh_c = keys & ~seen_q;
    assign below_c = ({{(NKEYS-1){1'b0}}, 1'b1} << key_idx) - {{(NKEYS-1){1'b0}}, 1'b1};

    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> since_q == DIV);
    a_r2_tick_due: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == DIV) |-> tick);
    a_r3_dly_load: assert property (@(posedge clk) disable iff (!rst_n)
        dly_wr |=> dly_value == $past(dly_wdata));
    a_r3_snd_load: assert property (@(posedge clk) disable iff (!rst_n)
        snd_wr |=> snd_value == $past(snd_wdata));
    a_r4_dly_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dly_wr && dly_value != '0) |=> dly_value == $past(dly_value) - TW'(1));
    a_r4_dly_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !dly_wr) |=> $stable(dly_value));
    a_r5_dly_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_value == '0 && !dly_wr) |=> dly_value == '0);
    a_r5_snd_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_value == '0 && !snd_wr) |=> snd_value == '0);
    a_r7_tone_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_wr && snd_wdata != '0) |=> sound_on);
    a_r8_stall_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_req && fresh_c == '0) |-> (stall && !key_found));
    a_r9_found_is_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        key_found |-> (fresh_c[key_idx] && !stall));
    a_r10_lowest_key: assert property (@(posedge clk) disable iff (!rst_n)
        key_found |-> ((fresh_c & below_c) == '0));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_req |-> (!stall && !key_found));
    a_r12_dly_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_wr && !dly_wr && !tick) |=> $stable(dly_value));
endmodule

bind countdown_keywait cdk_checker #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .TW(TW), .NKEYS(NKEYS)
) u_cdk_checker (
    .clk(clk), .rst_n(rst_n), .dly_wr(dly_wr), .dly_wdata(dly_wdata),
    .snd_wr(snd_wr), .snd_wdata(snd_wdata), .keys(keys), .wait_req(wait_req),
    .dly_value(dly_value), .snd_value(snd_value), .sound_on(sound_on),
    .tick(tick), .stall(stall), .key_found(key_found), .key_idx(key_idx)
);

// File: tb/countdown_keywait_bench.sv
module countdown_keywait_bench;
    localparam int unsigned CLK_HZ  = 600;
    localparam int unsigned TICK_HZ = 60;
    localparam int unsigned DIV     = CLK_HZ / TICK_HZ;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dly_wr = 1'b0, snd_wr = 1'b0;
    logic [7:0]  dly_wdata = '0, snd_wdata = '0;
    logic [15:0] keys = '0;
    logic        wait_req = 1'b0;
    logic [7:0]  dly_value, snd_value;
    logic        sound_on, tick, stall, key_found;
    logic [3:0]  key_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int exp_dly  = 0;
    int exp_snd  = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    countdown_keywait #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_countdown_keywait (
        .clk(clk), .rst_n(rst_n), .dly_wr(dly_wr), .dly_wdata(dly_wdata),
        .snd_wr(snd_wr), .snd_wdata(snd_wdata), .keys(keys), .wait_req(wait_req),
        .dly_value(dly_value), .snd_value(snd_value), .sound_on(sound_on),
        .tick(tick), .stall(stall), .key_found(key_found), .key_idx(key_idx)
    );

    // Expected timer values from the requirements: write first, else tick-driven step down to zero.
    always @(posedge clk) begin
        if (rst_n) begin
            bit tick_now;
            tick_now = (cyc > 0) && (cyc % DIV == 0);
            if (dly_wr) exp_dly = dly_wdata;
            else if (tick_now && exp_dly != 0) exp_dly = exp_dly - 1;
            if (snd_wr) exp_snd = snd_wdata;
            else if (tick_now && exp_snd != 0) exp_snd = exp_snd - 1;
            cyc = cyc + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic step_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            chk("R2 tick", int'(tick), int'((cyc > 0) && (cyc % DIV == 0)));
            chk(exp_dly == 0 ? "R5 delay floor" : "R4 delay value", int'(dly_value), exp_dly);
            chk(exp_snd == 0 ? "R5 sound floor" : "R4 sound value", int'(snd_value), exp_snd);
            chk("R7 sound_on", int'(sound_on), int'(exp_snd != 0));
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        keys = 16'h0001;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset delay", int'(dly_value), 0);
        chk("R1 reset sound", int'(snd_value), 0);
        chk("R1 reset tone", int'(sound_on), 0);
        chk("R1 reset tick", int'(tick), 0);
        chk("R1 reset stall", int'(stall), 0);
        rst_n = 1'b1;
        wait_req = 1'b1;
        #1;
        chk("R1 key held through reset not new", int'(stall), 1);
        chk("R1 key held through reset no found", int'(key_found), 0);
        @(negedge clk);
        wait_req = 1'b0;
        keys = '0;

        // R2/R4/R5/R7 sweep with loads
        step_check(3 * DIV);
        @(negedge clk); dly_wr = 1; dly_wdata = 8'd5; snd_wr = 1; snd_wdata = 8'd2;
        @(negedge clk); dly_wr = 0; snd_wr = 0;
        #1;
        chk("R3 delay load", int'(dly_value), 5);
        chk("R3 sound load", int'(snd_value), 2);
        step_check(8 * DIV);

        // R6: write on a tick cycle beats the decrement
        @(negedge clk); dly_wr = 1; dly_wdata = 8'd40; snd_wr = 1; snd_wdata = 8'd3;
        @(negedge clk); dly_wr = 0; snd_wr = 0;
        while (!((cyc > 0) && (cyc % DIV == 0))) @(negedge clk);
        dly_wr = 1; dly_wdata = 8'd9;
        @(negedge clk); dly_wr = 0;
        #1;
        chk("R6 write wins over tick", int'(dly_value), 9);
        chk("R6 other timer still steps", int'(snd_value), 2);

        // R12: sound write leaves delay alone
        @(negedge clk); snd_wr = 1; snd_wdata = 8'd200;
        @(negedge clk); snd_wr = 0;
        #1;
        chk("R12 delay untouched", int'(dly_value), exp_dly);
        chk("R12 sound loaded", int'(snd_value), 200);
        step_check(12 * DIV);

        // R8/R9 every key
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); keys = '0; wait_req = 0;
            @(negedge clk); wait_req = 1;
            #1;
            chk("R8 stall pending", int'(stall), 1);
            chk("R8 no found pending", int'(key_found), 0);
            @(negedge clk); keys = 16'(1) << k;
            #1;
            chk("R9 found", int'(key_found), 1);
            chk("R9 stall released", int'(stall), 0);
            chk("R9 key index", int'(key_idx), k);
            @(negedge clk);
            #1;
            chk("R9 held key not new", int'(stall), 1);
            wait_req = 0;
        end

        // R10 lowest wins, several patterns per key
        for (int k = 0; k < 16; k++) begin
            for (int p = 0; p < 3; p++) begin
                logic [15:0] pat;
                pat = (p == 0) ? (16'hFFFF << k) : (p == 1) ? ((16'(1) << k) | 16'h8000) : ((16'(1) << k) | (16'hAAAA & (16'hFFFF << k)));
                @(negedge clk); keys = '0; wait_req = 0;
                @(negedge clk); wait_req = 1; keys = pat;
                #1;
                chk("R10 lowest index", int'(key_idx), k);
                chk("R10 found", int'(key_found), 1);
            end
        end

        // R11 presses without wait
        @(negedge clk); wait_req = 0; keys = '0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); keys = 16'(1) << k;
            #1;
            chk("R11 no stall idle", int'(stall), 0);
            chk("R11 no found idle", int'(key_found), 0);
        end
        // a key pressed while idle and held does not end a later wait
        @(negedge clk); wait_req = 1;
        #1;
        chk("R9 pre-held key ignored", int'(stall), 1);
        @(negedge clk); wait_req = 0; keys = '0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule